// File: doc/BRIEF.md
# Ethernet PHY Link Bring-Up Sequencer

This block drives the standard management registers of an Ethernet PHY through a simple request/response port toward an MDIO master. Three commands are offered: a PHY reset with bounded polling for the self-clearing reset bit, an auto-negotiation start that programs the advertised abilities and restarts negotiation, and a link query that resolves the negotiated speed, duplex and pause capabilities.

Each command runs as a short chain of single register transactions. Only one transaction is outstanding at a time. A one-cycle `done` pulse closes every command. The status flags (timeout, link down, not ready) are valid on that pulse and hold until the next command starts. The speed/duplex code and the two pause fields hold the result of the most recent link query.

Management register numbers used: 0 (control), 1 (status), 4 (local advertisement), 5 (partner ability). The frame serialisation itself happens in the MDIO master on the other side of the request port.

Top module: `phy_linkup_seq`

## Requirements
- R1: A reset command writes 0x8000 to register 0, then reads register 0 repeatedly. If bit 15 reads clear on read number k and k is below `poll_limit`, the command ends with no flag set after exactly k reads.
- R2: If bit 15 has not been seen clear before the read count reaches `poll_limit`, the command ends with `flag_timeout` after exactly max(`poll_limit`,1) reads. A clear bit on the read that reaches the limit still counts as a timeout.
- R3: A negotiate command performs exactly three transactions in this order: a write of the advertisement to register 4, a write of 0x1200 (bits 12 and 9) to register 0, and one read of register 4. The advertisement is 0x01E1 when `flow_ctrl_en` is low and 0x0DE1 (bits 10 and 11 added) when it is high, sampled when the command is accepted.
- R4: A link query always reads register 1 twice in a row and decides only on the second value; the first value has no effect on any result.
- R5: If bit 2 of the second status value is clear, the query ends with `flag_link_down`, `speed_code` 0, `partner_pause` 0, and register 5 is not read.
- R6: If bit 2 is set but bit 5 is clear, the query ends with `flag_not_ready`, `speed_code` 0, `partner_pause` 0, and register 5 is not read.
- R7: Otherwise register 5 is read once and `speed_code` takes the highest set ability in the order bit 8 (code 4, 100 full), bit 7 (code 3, 100 half), bit 6 (code 2, 10 full), bit 5 (code 1, 10 half).
- R8: If none of register 5 bits 8..5 is set, the query ends with `flag_link_down` and `speed_code` 0 (no link).
- R9: Every completed query sets `local_pause` to {advertisement bit 10, advertisement bit 11} of the last advertisement written. The stored advertisement is zero after `rst`, so a query before any negotiate command gives 2'b00.
- R10: `partner_pause` is {register 5 bit 10, register 5 bit 11} when register 5 was read, otherwise 2'b00.
- R11: Commands arriving while `busy` is high are ignored. When more than one command is raised in the same idle cycle, reset wins over negotiate, which wins over query.
- R12: `done` is a single-cycle pulse, one per accepted command. At most one flag is set on it, and all flags are cleared when a new command is accepted. After `rst`, `busy`, `done`, `req_valid`, every flag, `speed_code` and both pause fields are 0.
- R13: While `req_valid` is high and `req_ready` is low, `req_write`, `req_reg` and `req_wdata` hold steady. A new request is raised only after `rsp_valid` has closed the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_reset | input | 1 | Start the PHY reset sequence |
| cmd_negotiate | input | 1 | Start the advertisement and auto-negotiation sequence |
| cmd_query | input | 1 | Start the link query |
| flow_ctrl_en | input | 1 | Advertise pause abilities in the next negotiation |
| poll_limit | input | POLL_W | Maximum number of reset poll reads; hold steady during a reset command |
| req_valid | output | 1 | Management transaction request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_reg | output | 5 | PHY register number |
| req_wdata | output | 16 | Write data |
| req_ready | input | 1 | Request accepted by the MDIO master |
| rsp_valid | input | 1 | Transaction finished (read data valid for reads) |
| rsp_rdata | input | 16 | Read data |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| speed_code | output | 3 | 0 none, 1 10-half, 2 10-full, 3 100-half, 4 100-full |
| local_pause | output | 2 | Local pause pair {sym, asym} |
| partner_pause | output | 2 | Partner pause pair {sym, asym} |
| flag_timeout | output | 1 | Reset poll limit reached |
| flag_link_down | output | 1 | Link down or no common ability |
| flag_not_ready | output | 1 | Negotiation not complete |

## Verification
A sequencer stuck or misrouted in its state shows up as the wrong transaction order or count at the request port within one command. The bench logs every accepted request from a PHY model and compares it to the expected list. A wrong poll count is visible as a read count differing by one on the very reset command that hits the limit. A stale or mis-selected status word or ability decode appears as wrong flags, speed code or pause pairs on the same `done` pulse. A lost or stored advertisement error shows on the next query's local pause pair.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int DATA_W = 16;
    localparam int REG_W  = 5;

    // management register numbers
    localparam logic [REG_W-1:0] REG_CTRL = 5'd0;
    localparam logic [REG_W-1:0] REG_STAT = 5'd1;
    localparam logic [REG_W-1:0] REG_ADV  = 5'd4;
    localparam logic [REG_W-1:0] REG_PART = 5'd5;

    // bit positions
    localparam int CTL_SOFT_RESET = 15;
    localparam int CTL_AN_ENABLE  = 12;
    localparam int CTL_AN_RESTART = 9;
    localparam int STS_LINK       = 2;
    localparam int STS_AN_DONE    = 5;
    localparam int ABL_ASYM       = 11;
    localparam int ABL_SYM        = 10;
    localparam int ABL_100F       = 8;
    localparam int ABL_100H       = 7;
    localparam int ABL_10F        = 6;
    localparam int ABL_10H        = 5;
    localparam int ABL_SELECT     = 0;

    typedef enum logic [2:0] {
        SPD_NONE = 3'd0,
        SPD_10H  = 3'd1,
        SPD_10F  = 3'd2,
        SPD_100H = 3'd3,
        SPD_100F = 3'd4
    } speed_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_WR,
        S_RST_POLL,
        S_AN_ADV,
        S_AN_CTL,
        S_AN_RB,
        S_Q_ST1,
        S_Q_ST2,
        S_Q_PART
    } seq_state_e;

    typedef enum logic [1:0] {
        X_IDLE,
        X_REQ,
        X_WAIT
    } xact_state_e;

    typedef struct packed {
        logic              wr;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } xact_req_t;

    typedef struct packed {
        logic timeout;
        logic link_down;
        logic not_ready;
    } seq_flags_t;

    function automatic logic [DATA_W-1:0] soft_reset_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_SOFT_RESET] = 1'b1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] an_start_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_AN_ENABLE]  = 1'b1;
        w[CTL_AN_RESTART] = 1'b1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] adv_word(input logic flow);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ABL_SELECT] = 1'b1;
        w[ABL_10H]    = 1'b1;
        w[ABL_10F]    = 1'b1;
        w[ABL_100H]   = 1'b1;
        w[ABL_100F]   = 1'b1;
        if (flow) begin
            w[ABL_SYM]  = 1'b1;
            w[ABL_ASYM] = 1'b1;
        end
        return w;
    endfunction

    function automatic logic [1:0] pause_pair(input logic [DATA_W-1:0] w);
        return {w[ABL_SYM], w[ABL_ASYM]};
    endfunction

    function automatic speed_e best_speed(input logic [DATA_W-1:0] w);
        speed_e s;
        if (w[ABL_100F])      s = SPD_100F;
        else if (w[ABL_100H]) s = SPD_100H;
        else if (w[ABL_10F])  s = SPD_10F;
        else if (w[ABL_10H])  s = SPD_10H;
        else                  s = SPD_NONE;
        return s;
    endfunction

endpackage

// File: rtl/phy_seq_xact.sv
module phy_seq_xact
    import phy_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  xact_req_t         issue_req,
    output logic              idle,
    output logic              fin,
    output logic [DATA_W-1:0] fin_data,
    output logic              req_valid,
    output logic              req_write,
    output logic [REG_W-1:0]  req_reg,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata
);

    xact_state_e st;
    xact_req_t   held;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= X_IDLE;
            held <= '0;
        end else begin
            unique case (st)
                X_IDLE: begin
                    if (issue) begin
                        held <= issue_req;
                        st   <= X_REQ;
                    end
                end
                X_REQ: begin
                    if (req_ready) begin
                        st <= X_WAIT;
                    end
                end
                X_WAIT: begin
                    if (rsp_valid) begin
                        st <= X_IDLE;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (st == X_IDLE);
        req_valid = (st == X_REQ);
        req_write = held.wr;
        req_reg   = held.regad;
        req_wdata = held.wdata;
        fin       = (st == X_WAIT) && rsp_valid;
        fin_data  = rsp_rdata;
    end

endmodule

// File: rtl/phy_seq_poll.sv
module phy_seq_poll #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         at_limit
);

    localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

    logic [W-1:0] reads;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            reads <= '0;
        end else if (step) begin
            reads <= reads + 1'b1;
        end
    end

    // true when the read now finishing is the limit-th (or later) one
    always_comb begin
        at_limit = ({1'b0, reads} + ONE) >= {1'b0, limit};
    end

endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
    import phy_seq_pkg::*;
#(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_reset,
    input  logic              cmd_negotiate,
    input  logic              cmd_query,
    input  logic              flow_ctrl_en,
    input  logic              xact_idle,
    input  logic              xact_fin,
    input  logic [DATA_W-1:0] xact_data,
    input  logic              poll_at_limit,
    output logic              issue,
    output xact_req_t         issue_req,
    output logic              poll_clr,
    output logic              poll_step,
    output logic              busy,
    output logic              done,
    output speed_e            speed,
    output logic [1:0]        local_pause,
    output logic [1:0]        partner_pause,
    output seq_flags_t        flags
);

    seq_state_e        state;
    logic              pend;
    logic [DATA_W-1:0] adv_q;
    speed_e            part_speed;

    always_comb begin
        issue_req = '0;
        unique case (state)
            S_RST_WR: begin
                issue_req.wr    = 1'b1;
                issue_req.regad = REG_CTRL;
                issue_req.wdata = soft_reset_word();
            end
            S_RST_POLL: issue_req.regad = REG_CTRL;
            S_AN_ADV: begin
                issue_req.wr    = 1'b1;
                issue_req.regad = REG_ADV;
                issue_req.wdata = adv_q;
            end
            S_AN_CTL: begin
                issue_req.wr    = 1'b1;
                issue_req.regad = REG_CTRL;
                issue_req.wdata = an_start_word();
            end
            S_AN_RB:  issue_req.regad = REG_ADV;
            S_Q_ST1,
            S_Q_ST2:  issue_req.regad = REG_STAT;
            S_Q_PART: issue_req.regad = REG_PART;
            default:  issue_req = '0;
        endcase
    end

    always_comb begin
        busy       = (state != S_IDLE);
        issue      = busy && !pend && xact_idle;
        poll_clr   = (state == S_IDLE) && cmd_reset;
        poll_step  = (state == S_RST_POLL) && xact_fin;
        part_speed = best_speed(xact_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            pend          <= 1'b0;
            adv_q         <= '0;
            done          <= 1'b0;
            speed         <= SPD_NONE;
            local_pause   <= 2'b00;
            partner_pause <= 2'b00;
            flags         <= '0;
        end else begin
            done <= 1'b0;
            if (issue) begin
                pend <= 1'b1;
            end
            if (xact_fin) begin
                pend <= 1'b0;
            end

            unique case (state)
                S_IDLE: begin
                    if (cmd_reset) begin
                        flags <= '0;
                        state <= S_RST_WR;
                    end else if (cmd_negotiate) begin
                        flags <= '0;
                        adv_q <= adv_word(flow_ctrl_en);
                        state <= S_AN_ADV;
                    end else if (cmd_query) begin
                        flags <= '0;
                        state <= S_Q_ST1;
                    end
                end

                S_RST_WR: begin
                    if (xact_fin) state <= S_RST_POLL;
                end

                S_RST_POLL: begin
                    if (xact_fin) begin
                        if (poll_at_limit) begin
                            flags.timeout <= 1'b1;
                            state         <= S_IDLE;
                            done          <= 1'b1;
                        end else if (!xact_data[CTL_SOFT_RESET]) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end

                S_AN_ADV: begin
                    if (xact_fin) state <= S_AN_CTL;
                end

                S_AN_CTL: begin
                    if (xact_fin) state <= S_AN_RB;
                end

                S_AN_RB: begin
                    if (xact_fin) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end

                S_Q_ST1: begin
                    // first status value is latched history and is dropped
                    if (xact_fin) state <= S_Q_ST2;
                end

                S_Q_ST2: begin
                    if (xact_fin) begin
                        local_pause <= pause_pair(adv_q);
                        if (!xact_data[STS_LINK]) begin
                            flags.link_down <= 1'b1;
                            speed           <= SPD_NONE;
                            partner_pause   <= 2'b00;
                            state           <= S_IDLE;
                            done            <= 1'b1;
                        end else if (!xact_data[STS_AN_DONE]) begin
                            flags.not_ready <= 1'b1;
                            speed           <= SPD_NONE;
                            partner_pause   <= 2'b00;
                            state           <= S_IDLE;
                            done            <= 1'b1;
                        end else begin
                            state <= S_Q_PART;
                        end
                    end
                end

                S_Q_PART: begin
                    if (xact_fin) begin
                        partner_pause <= pause_pair(xact_data);
                        speed         <= part_speed;
                        if (part_speed == SPD_NONE) begin
                            flags.link_down <= 1'b1;
                        end
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end

                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
    import phy_seq_pkg::*;
#(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_reset,
    input  logic              cmd_negotiate,
    input  logic              cmd_query,
    input  logic              flow_ctrl_en,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              req_valid,
    output logic              req_write,
    output logic [4:0]        req_reg,
    output logic [15:0]       req_wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [15:0]       rsp_rdata,
    output logic              busy,
    output logic              done,
    output logic [2:0]        speed_code,
    output logic [1:0]        local_pause,
    output logic [1:0]        partner_pause,
    output logic              flag_timeout,
    output logic              flag_link_down,
    output logic              flag_not_ready
);

    logic              x_issue;
    xact_req_t         x_req;
    logic              x_idle;
    logic              x_fin;
    logic [DATA_W-1:0] x_data;
    logic              p_clr;
    logic              p_step;
    logic              p_at_limit;
    speed_e            spd;
    seq_flags_t        flg;

    phy_seq_xact u_xact (
        .clk       (clk),
        .rst       (rst),
        .issue     (x_issue),
        .issue_req (x_req),
        .idle      (x_idle),
        .fin       (x_fin),
        .fin_data  (x_data),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    phy_seq_poll #(.W(POLL_W)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .clr      (p_clr),
        .step     (p_step),
        .limit    (poll_limit),
        .at_limit (p_at_limit)
    );

    phy_seq_fsm #(.POLL_W(POLL_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd_reset     (cmd_reset),
        .cmd_negotiate (cmd_negotiate),
        .cmd_query     (cmd_query),
        .flow_ctrl_en  (flow_ctrl_en),
        .xact_idle     (x_idle),
        .xact_fin      (x_fin),
        .xact_data     (x_data),
        .poll_at_limit (p_at_limit),
        .issue         (x_issue),
        .issue_req     (x_req),
        .poll_clr      (p_clr),
        .poll_step     (p_step),
        .busy          (busy),
        .done          (done),
        .speed         (spd),
        .local_pause   (local_pause),
        .partner_pause (partner_pause),
        .flags         (flg)
    );

    always_comb begin
        speed_code     = spd;
        flag_timeout   = flg.timeout;
        flag_link_down = flg.link_down;
        flag_not_ready = flg.not_ready;
    end

endmodule

// File: rtl/phy_linkup_seq_chk.sv
module phy_linkup_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [4:0]  req_reg,
    input logic [15:0] req_wdata,
    input logic        busy,
    input logic        done,
    input logic [2:0]  speed_code,
    input logic [1:0]  partner_pause,
    input logic        flag_timeout,
    input logic        flag_link_down,
    input logic        flag_not_ready
);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write)
                                       && $stable(req_reg) && $stable(req_wdata)));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_one_flag_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0({flag_timeout, flag_link_down, flag_not_ready}));

    assert_speed_code_R7: assert property (@(posedge clk) disable iff (rst)
        speed_code <= 3'd4);

    assert_nolink_code_R8: assert property (@(posedge clk) disable iff (rst)
        (done && (flag_link_down || flag_not_ready)) |-> (speed_code == 3'd0));

    assert_partner_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (done && flag_not_ready) |-> (partner_pause == 2'b00));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

endmodule

bind phy_linkup_seq phy_linkup_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_reg        (req_reg),
    .req_wdata      (req_wdata),
    .busy           (busy),
    .done           (done),
    .speed_code     (speed_code),
    .partner_pause  (partner_pause),
    .flag_timeout   (flag_timeout),
    .flag_link_down (flag_link_down),
    .flag_not_ready (flag_not_ready)
);

// File: tb/sim_phy_linkup_seq.sv
`timescale 1ns/1ps
module sim_phy_linkup_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_reset, cmd_negotiate, cmd_query, flow_ctrl_en;
    logic [15:0] poll_limit;
    logic        req_valid, req_write;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        busy, done;
    logic [2:0]  speed_code;
    logic [1:0]  local_pause, partner_pause;
    logic        flag_timeout, flag_link_down, flag_not_ready;

    always #2.5 clk = ~clk;

    phy_linkup_seq u0 (
        .clk(clk), .rst(rst), .cmd_reset(cmd_reset), .cmd_negotiate(cmd_negotiate),
        .cmd_query(cmd_query), .flow_ctrl_en(flow_ctrl_en), .poll_limit(poll_limit),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .speed_code(speed_code),
        .local_pause(local_pause), .partner_pause(partner_pause),
        .flag_timeout(flag_timeout), .flag_link_down(flag_link_down),
        .flag_not_ready(flag_not_ready)
    );

    int n_vec = 0;
    int n_bad = 0;

    // PHY model state, set by the bench between commands
    int          busy_left;
    logic [15:0] st_first, st_second, part_word;
    int          st_idx;
    logic [15:0] reg4_val;
    // transaction log
    logic [5:0]  op_log [0:63];
    logic [15:0] wd_log [0:63];
    int          op_n, n_wr, n_rd0, n_rd1, n_rd5;
    // model internals
    bit          m_wait;
    int          m_delay;
    logic [15:0] m_data;

    task automatic clear_log();
        op_n = 0; n_wr = 0; n_rd0 = 0; n_rd1 = 0; n_rd5 = 0; st_idx = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            req_ready <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            m_wait = 0;
        end else begin
            rsp_valid <= 1'b0;
            if (m_wait) begin
                if (m_delay == 0) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= m_data;
                    m_wait = 0;
                end else begin
                    m_delay = m_delay - 1;
                end
                req_ready <= 1'b0;
            end else if (req_valid && req_ready) begin
                if (op_n < 64) begin
                    op_log[op_n] = {req_write, req_reg};
                    wd_log[op_n] = req_wdata;
                end
                op_n = op_n + 1;
                m_data = 16'h0000;
                if (req_write) begin
                    n_wr = n_wr + 1;
                    if (req_reg == 5'd4) reg4_val = req_wdata;
                end else begin
                    case (req_reg)
                        5'd0: begin
                            n_rd0 = n_rd0 + 1;
                            if (busy_left > 0) begin
                                busy_left = busy_left - 1;
                                m_data = 16'h9140;
                            end else begin
                                m_data = 16'h1140;
                            end
                        end
                        5'd1: begin
                            n_rd1 = n_rd1 + 1;
                            m_data = (st_idx == 0) ? st_first : st_second;
                            st_idx = st_idx + 1;
                        end
                        5'd4: m_data = reg4_val;
                        5'd5: begin
                            n_rd5 = n_rd5 + 1;
                            m_data = part_word;
                        end
                        default: m_data = 16'hFFFF;
                    endcase
                end
                m_delay = $urandom % 3;
                m_wait = 1;
                req_ready <= 1'b0;
            end else begin
                req_ready <= (($urandom % 3) != 0);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // pulse commands for one cycle, then wait for done; checks R12 pulse width
    task automatic run_cmd(input bit r, input bit n, input bit q);
        bit seen;
        clear_log();
        @(negedge clk);
        cmd_reset = r; cmd_negotiate = n; cmd_query = q;
        @(negedge clk);
        cmd_reset = 0; cmd_negotiate = 0; cmd_query = 0;
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R12 done pulse seen", seen, 1);
        @(negedge clk);
        chk("R12 done single cycle", done, 0);
    endtask

    // expected-value bench state
    logic [15:0] exp_adv;

    task automatic do_reset(input int b, input int lim);
        int exp_rd;
        bit exp_to;
        busy_left = b;
        poll_limit = lim[15:0];
        if (b + 1 < lim) begin exp_rd = b + 1; exp_to = 0; end
        else begin exp_rd = (lim < 1) ? 1 : lim; exp_to = 1; end
        run_cmd(1, 0, 0);
        chk("R1 first op is write reg0", op_log[0], {1'b1, 5'd0});
        chk("R1 reset word", wd_log[0], 16'h8000);
        chk("R1 R2 poll read count", n_rd0, exp_rd);
        chk("R2 timeout flag", flag_timeout, exp_to);
        chk("R12 other flags clear", {flag_link_down, flag_not_ready}, 0);
    endtask

    task automatic do_neg(input bit flow);
        flow_ctrl_en = flow;
        exp_adv = flow ? 16'h0DE1 : 16'h01E1;
        run_cmd(0, 1, 0);
        chk("R3 op count", op_n, 3);
        chk("R3 op0 write reg4", op_log[0], {1'b1, 5'd4});
        chk("R3 advertisement", wd_log[0], exp_adv);
        chk("R3 op1 write reg0", op_log[1], {1'b1, 5'd0});
        chk("R3 control word", wd_log[1], 16'h1200);
        chk("R3 op2 read reg4", op_log[2], {1'b0, 5'd4});
        chk("R12 no flags after negotiate",
            {flag_timeout, flag_link_down, flag_not_ready}, 0);
    endtask

    task automatic do_query(input logic [15:0] s1, input logic [15:0] s2, input logic [15:0] p);
        logic [2:0] e_sp;
        logic [1:0] e_lp, e_pp;
        bit e_ld, e_nr;
        int e_rd5;
        st_first = s1; st_second = s2; part_word = p;
        e_lp = {exp_adv[10], exp_adv[11]};
        e_ld = 0; e_nr = 0; e_sp = 0; e_pp = 0; e_rd5 = 0;
        if (!s2[2]) e_ld = 1;
        else if (!s2[5]) e_nr = 1;
        else begin
            e_rd5 = 1;
            e_pp = {p[10], p[11]};
            if (p[8]) e_sp = 4;
            else if (p[7]) e_sp = 3;
            else if (p[6]) e_sp = 2;
            else if (p[5]) e_sp = 1;
            else e_ld = 1;
        end
        run_cmd(0, 0, 1);
        chk("R4 two status reads", n_rd1, 2);
        chk("R4 first two ops read reg1", {op_log[0], op_log[1]}, {6'd1, 6'd1});
        chk("R5 R6 partner read count", n_rd5, e_rd5);
        chk("R5 R8 link down flag", flag_link_down, e_ld);
        chk("R6 not ready flag", flag_not_ready, e_nr);
        chk("R7 speed code", speed_code, e_sp);
        chk("R9 local pause", local_pause, e_lp);
        chk("R10 partner pause", partner_pause, e_pp);
        chk("R11 no writes in query", n_wr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1; cmd_reset = 0; cmd_negotiate = 0; cmd_query = 0;
        flow_ctrl_en = 0; poll_limit = 16'd8;
        busy_left = 0; st_first = 0; st_second = 0; part_word = 0;
        reg4_val = 0; exp_adv = 16'h0000;
        clear_log();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset busy/done/req", {busy, done, req_valid}, 0);
        chk("R12 reset results", {speed_code, local_pause, partner_pause}, 0);
        chk("R12 reset flags", {flag_timeout, flag_link_down, flag_not_ready}, 0);

        // R9 query before any negotiation: local pause zero
        do_query(16'h0000, 16'h0024, 16'h0DE1);

        // R1 / R2 directed corners
        do_reset(0, 4);
        do_reset(2, 4);
        do_reset(3, 4);      // clears on the limit-th read: still timeout
        do_reset(6, 3);
        do_reset(0, 0);      // zero limit: one read, timeout
        do_reset(0, 1);

        // R3 both advertisement variants
        do_neg(0);
        do_query(16'h0024, 16'h0024, 16'h0C20);
        do_neg(1);

        // R4 stale first value: good then bad, bad then good
        do_query(16'h0024, 16'h0000, 16'h0100);
        do_query(16'h0000, 16'h0024, 16'h0100);
        // R6 not ready
        do_query(16'h0000, 16'h0004, 16'h0DE0);
        // R7 priority walk
        do_query(16'h0000, 16'h0024, 16'h01E0);
        do_query(16'h0000, 16'h0024, 16'h00E0);
        do_query(16'h0000, 16'h0024, 16'h0060);
        do_query(16'h0000, 16'h0024, 16'h0020);
        // R8 no ability
        do_query(16'h0000, 16'h0024, 16'h0C1F);

        // R11 commands during busy are ignored
        st_first = 16'h0024; st_second = 16'h0024; part_word = 16'h0100;
        clear_log();
        @(negedge clk);
        cmd_query = 1;
        @(negedge clk);
        cmd_query = 0; cmd_reset = 1; cmd_negotiate = 1;
        @(negedge clk);
        cmd_reset = 0; cmd_negotiate = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        chk("R11 busy commands ignored: no writes", n_wr, 0);
        chk("R11 busy commands ignored: op count", op_n, 3);
        chk("R11 idle after query", busy, 0);
        chk("R11 speed from query", speed_code, 3'd4);

        // R11 priority: reset beats query
        busy_left = 0;
        poll_limit = 16'd5;
        run_cmd(1, 1, 1);
        chk("R11 reset wins: first op write reg0", op_log[0], {1'b1, 5'd0});
        chk("R11 reset wins: no status reads", n_rd1, 0);
        // R11 priority: negotiate beats query
        flow_ctrl_en = 0;
        exp_adv = 16'h01E1;
        run_cmd(0, 1, 1);
        chk("R11 negotiate wins: advertisement", wd_log[0], 16'h01E1);
        chk("R11 negotiate wins: no status reads", n_rd1, 0);

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            int sel;
            sel = $urandom % 5;
            if (sel == 0) begin
                do_reset($urandom % 6, $urandom % 8);
            end else if (sel == 1) begin
                do_neg($urandom % 2);
            end else begin
                logic [15:0] a, b, c;
                a = $urandom;
                b = $urandom;
                c = $urandom;
                if (($urandom % 4) != 0) b = b | 16'h0024;
                if (($urandom % 3) == 0) c = c & 16'hFE1F;
                do_query(a, b, c);
            end
        end

        summary();
        $finish;
    end

endmodule